// File: doc/BRIEF.md
# Bit-Field Insert Unit with Condition Flags

This block writes a field of bits into a 32-bit word in one clock cycle. Three operands go in together: a base word, an insert value, and a 16-bit control word. The control word holds the bit position where the field starts and the length of the field. The unit replaces that part of the base with the low bits of the insert value. Every other bit of the base stays as it was.

Out-of-range controls are clamped:
- A start position of 32 or more leaves the base word as it is.
- A length above 32 is cut down to the room left between the start position and bit 31.
- Any part of a field that would reach past bit 31 is dropped.

When requested, the unit also updates four condition flags: zero, sign, carry and overflow.

An operation is taken in on a cycle where `in_valid` is high. The result, the flags and `out_valid` are registered and appear on the next clock edge. The flags and `out_valid` are cleared by a synchronous reset. The flags keep their value unless an accepted operation asks for a flag update.

Top module: `bitfield_insert_flags`

## Requirements
- R1: The start position is `ctrl_word[7:0]`, unsigned. If it is 32 or greater, the result equals `base_word` unchanged.
- R2: The requested length is `ctrl_word[15:8]`, unsigned. If it is greater than 32, the length used is 32 minus the start position. A length of exactly 32 is used as given.
- R3: The low bits of `ins_word`, as many as the length used, replace the base bits starting at the start position. All other base bits are kept.
- R4: A start position of 0 is a normal insertion at bit 0. It is not a pass-through.
- R5: Field bits that would land above bit 31 (start plus length greater than 32) are dropped. Only bits 0 to 31 are written.
- R6: A length of zero leaves the base word unchanged.
- R7: On an accepted operation with `flag_en` high, `flag_z` is set when the result is zero. In the same case, `flag_s` is set when bit 31 of the result is one.
- R8: On an accepted operation with `flag_en` high, `flag_c` and `flag_v` are cleared.
- R9: The flags hold their value on any cycle without an accepted flag-updating operation.
- R10: `result` and `out_valid` are registered one cycle after `in_valid`. Reset clears `out_valid` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| flag_en | input | 1 | Update the condition flags with this operation |
| base_word | input | 32 | Word that receives the field |
| ins_word | input | 32 | Source of the field bits (low bits are used) |
| ctrl_word | input | 16 | Start position in bits [7:0], length in bits [15:8] |
| result | output | 32 | Registered result word |
| out_valid | output | 1 | Result is valid |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The vector table covers:
- ordinary fields in the middle of a word, and a field at bit 0 (the zero start position must not pass the base through);
- start positions of exactly 32 and far above it;
- lengths of exactly 32, 33 and 255, which separate use-as-given from clipping;
- fields that run past bit 31, and a zero length.

All-ones insert values over zero bases show the exact mask position. A mixed pattern over a striped base shows that bits next to the field survive. Directed cases check that the flags keep their value when `flag_en` is low or no operation is accepted, and that reset clears them.

// File: rtl/bitfield_insert_flags.sv
module bitfield_insert_flags #(
  parameter int W  = 32,
  parameter int FW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            flag_en,
  input  logic [W-1:0]    base_word,
  input  logic [W-1:0]    ins_word,
  input  logic [2*FW-1:0] ctrl_word,
  output logic [W-1:0]    result,
  output logic            out_valid,
  output logic            flag_z,
  output logic            flag_s,
  output logic            flag_c,
  output logic            flag_v
);

  localparam logic [FW-1:0] WF = FW'(W);

  logic [FW-1:0] pos, req_len, use_len;
  logic [W-1:0]  len_mask, mask, ins_sh, ins_res;
  logic          pass;

  assign pos      = ctrl_word[FW-1:0];
  assign req_len  = ctrl_word[2*FW-1:FW];
  assign pass     = pos >= WF;
  assign use_len  = (req_len > WF) ? WF - pos : req_len;
  assign len_mask = (use_len >= WF) ? {W{1'b1}} : ((W'(1) << use_len) - W'(1));
  assign mask     = len_mask << pos;
  assign ins_sh   = ins_word << pos;
  assign ins_res  = pass ? base_word : ((base_word & ~mask) | (ins_sh & mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      out_valid <= 1'b0;
      flag_z    <= 1'b0;
      flag_s    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= ins_res;
        if (flag_en) begin
          flag_z <= (ins_res == '0);
          flag_s <= ins_res[W-1];
          flag_c <= 1'b0;
          flag_v <= 1'b0;
        end
      end
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_far_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pos >= WF) |=> (result == $past(base_word)));
  assert_zero_length_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && req_len == '0) |=> (result == $past(base_word)));
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flag_en) |=> (flag_z == (result == '0)) && (flag_s == result[W-1]));
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && flag_en) |=> $stable({flag_z, flag_s, flag_c, flag_v}));
  assert_low_field_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pos == '0 && req_len == FW'(1)) |=>
      (result == {$past(base_word[W-1:1]), $past(ins_word[0])}));

endmodule

// File: tb/bitfield_insert_flags_test.sv
module bitfield_insert_flags_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        flag_en = 1'b0;
  logic [31:0] base_word = '0;
  logic [31:0] ins_word = '0;
  logic [15:0] ctrl_word = '0;
  logic [31:0] result;
  logic        out_valid, flag_z, flag_s, flag_c, flag_v;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bitfield_insert_flags uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .flag_en(flag_en),
    .base_word(base_word), .ins_word(ins_word), .ctrl_word(ctrl_word),
    .result(result), .out_valid(out_valid),
    .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_v(flag_v)
  );

  localparam int NV = 11;
  // {base, insert, ctrl {len, pos}, expected}
  localparam logic [111:0] VEC [NV] = '{
    {32'h00000000, 32'hFFFFFFFF, 16'h0804, 32'h00000FF0}, // R3
    {32'hFFFFFFFF, 32'h00000000, 16'h1000, 32'hFFFF0000}, // R4
    {32'h12345678, 32'h0000ABCD, 16'h0820, 32'h12345678}, // R1
    {32'h00000000, 32'hFFFFFFFF, 16'h04C8, 32'h00000000}, // R1
    {32'h00000000, 32'hFFFFFFFF, 16'h2808, 32'hFFFFFF00}, // R2
    {32'h00000000, 32'hFFFFFFFF, 16'h2000, 32'hFFFFFFFF}, // R2
    {32'h00000000, 32'hFFFFFFFF, 16'h081C, 32'hF0000000}, // R5
    {32'hAAAAAAAA, 32'hFFFFFFFF, 16'h0004, 32'hAAAAAAAA}, // R6
    {32'hF0F0F0F0, 32'h00012345, 16'h080C, 32'hF0F450F0}, // R3
    {32'h00000000, 32'hFFFFFFFF, 16'h2104, 32'hFFFFFFF0}, // R2
    {32'h00000000, 32'hFFFFFFFF, 16'hFF1F, 32'h80000000}  // R5
  };

  function automatic string row_tag(int i);
    case (i)
      0, 8:    return "R3";
      1:       return "R4";
      2, 3:    return "R1";
      4, 5, 9: return "R2";
      6, 10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] b, logic [31:0] n, logic [15:0] c, logic fe);
    @(negedge clk);
    base_word = b; ins_word = n; ctrl_word = c; flag_en = fe; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_en = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid at reset", {31'b0, out_valid}, 32'h0);
    check("R10 flags at reset", {28'b0, flag_z, flag_s, flag_c, flag_v}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][111:80], VEC[i][79:48], VEC[i][47:32], 1'b1);
      check({row_tag(i), " result"}, result, VEC[i][31:0]);
      check("R10 out_valid", {31'b0, out_valid}, 32'h1);
      check("R7 flags", {30'b0, flag_z, flag_s},
            {30'b0, VEC[i][31:0] == 32'h0, VEC[i][31]});
      check("R8 carry/overflow", {30'b0, flag_c, flag_v}, 32'h0);
    end

    // R9: sign set, then a zero result without flag update
    issue(32'h0, 32'hFFFFFFFF, 16'h081C, 1'b1);
    issue(32'h0, 32'h0, 16'h0804, 1'b0);
    check("R9 result", result, 32'h0);
    check("R9 flags held", {30'b0, flag_z, flag_s}, 32'h1);

    // R10 and R9: idle cycle
    @(negedge clk);
    check("R10 idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R9 idle flags", {30'b0, flag_z, flag_s}, 32'h1);

    // R7: zero result sets Z, clears S
    issue(32'h00000001, 32'h0, 16'h0100, 1'b1);
    check("R4 single bit at 0", result, 32'h0);
    check("R7 zero flag", {30'b0, flag_z, flag_s}, 32'h2);

    // R1: exactly 32 with huge length
    issue(32'hDEADBEEF, 32'h0, 16'hFF20, 1'b1);
    check("R1 pos 32", result, 32'hDEADBEEF);

    // R10: reset clears flags
    issue(32'h80000000, 32'h0, 16'h0000, 1'b1);
    check("R7 sign", {30'b0, flag_z, flag_s}, 32'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears flags", {28'b0, flag_z, flag_s, flag_c, flag_v}, 32'h0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule